// File: doc/BRIEF.md
# I2C Serial Data Shifter with Arbitration Monitor

This block is the byte-wide serial data register of an I2C engine that can act as master or slave. It also watches for loss of bus arbitration. A byte is sent most significant bit first. On every sampled SCL rising edge, the bus level is shifted into the same register at bit 0. Because the register keeps capturing the wired-AND bus while it transmits, it holds the byte that actually appeared on the bus. When arbitration is lost in mid-byte, the register therefore already contains correct data for the change to slave receiver.

A clock generator and a sampler outside this block supply single-cycle strobes for SCL rising and falling edges and a synchronised SDA level. The surrounding controller does three things:

- It chooses a role and either loads a byte (`load`) or opens a receive byte (`start`).
- It supplies the acknowledge level to return (`ack_val`).
- It reads `clk_keep` to decide whether to keep producing SCL pulses.

Each byte consists of eight data bits followed by one acknowledge bit.

Top module: `i2c_byte_shifter`

## Requirements
- R1: During and after synchronous reset the outputs are: `sda_out`=1, `shreg`=0, `byte_done`=0, `ack_in`=1, `arb_lost`=0, `clk_keep`=1, and `role`=slave receiver.
- R2: `role` uses the codes 2'b00 slave receiver, 2'b01 slave transmitter, 2'b10 master receiver and 2'b11 master transmitter; bit 1 means master and bit 0 means transmit. A `load` or `start` is accepted only outside the eight data bits. When accepted, it takes `role` from `mode`, restarts the bit count, and with `load` copies `load_data` into `shreg`. During the data bits, both are ignored.
- R3: In a transmit role, `sda_out` presents `shreg` bit 7 from the cycle after an accepted load. After each SCL falling strobe it presents the new bit 7. In a receive role, `sda_out` stays 1 for the data bits.
- R4: Each SCL rising strobe during the data bits shifts `shreg` left by one and puts the bus level in bit 0. After eight bits, the first bit on the bus sits in bit 7 and `shreg` equals the bus byte.
- R5: `byte_done` is high for exactly one cycle: the cycle after the eighth data rising strobe.
- R6: At the acknowledge bit, receive roles drive `ack_val` after the falling strobe and transmit roles release (drive 1). `ack_in` takes the bus level at the acknowledge rising strobe. Outside a byte, `sda_out` returns to 1 at each falling strobe.
- R7: As master transmitter, when a driven 1 is sampled as 0 at a data rising strobe, the block does four things. It sets `arb_lost`, changes `role` to slave receiver at once, releases SDA for the remaining bits, and keeps `clk_keep` at 1 so that the byte finishes with `byte_done`.
- R8: As master receiver, when a driven not-acknowledge (1) is sampled as 0 at the acknowledge rising strobe, the block sets `arb_lost`, drops `clk_keep` to 0 and changes `role` to slave receiver.
- R9: There is no arbitration loss in slave roles, when the driven bit is 0, or when a master receiver returns an acknowledge (0).
- R10: `arb_lost` and a low `clk_keep` persist until a cycle with `arb_clr` high. That cycle sets `arb_lost` to 0 and `clk_keep` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_rise | input | 1 | One-cycle strobe at each sampled SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe at each sampled SCL falling edge |
| sda_in | input | 1 | Sampled SDA bus level |
| mode | input | 2 | Role for the next byte (codes as in R2) |
| load | input | 1 | Load `load_data` and begin a byte |
| load_data | input | 8 | Parallel byte to transmit |
| start | input | 1 | Begin a byte without loading |
| ack_val | input | 1 | Acknowledge level to return in receive roles |
| arb_clr | input | 1 | Clear arbitration-lost state |
| sda_out | output | 1 | SDA drive level, 1 means released |
| shreg | output | 8 | Shift register contents |
| byte_done | output | 1 | One-cycle pulse after the eighth data bit |
| ack_in | output | 1 | Acknowledge level sampled from the bus |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| clk_keep | output | 1 | High while the clock generator should keep clocking |
| role | output | 2 | Current role (codes as in R2) |

## Verification
The bench models a second bus device whose SDA is wired-AND with `sda_out`. It runs the following patterns:

- A master transmit against a silent peer shows that the register captures what it drives.
- A master transmit against a peer that pulls a 1 low mid-byte separates an immediate role change from an end-of-byte one. It also shows that the register ends up holding the peer's byte.
- Master receive runs with NACK against a low peer, NACK against a released peer, and ACK against a low peer. These separate the one arbitration case in that role from the cases that must not trip it.
- Slave transmit against a peer driving zeros, and a load issued in mid-byte, confirm that neither disturbs role or data.

// File: rtl/i2cbs_pkg.sv
package i2cbs_pkg;

  typedef enum logic [1:0] {
    ROLE_SRX = 2'b00,
    ROLE_STX = 2'b01,
    ROLE_MRX = 2'b10,
    ROLE_MTX = 2'b11
  } role_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_DATA = 2'b01,
    PH_ACK  = 2'b10,
    PH_DONE = 2'b11
  } phase_e;

endpackage

// File: rtl/i2cbs_phase_ctrl.sv
module i2cbs_phase_ctrl
  import i2cbs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   go,
  input  logic   scl_rise,
  output phase_e phase,
  output logic   data_rise,
  output logic   ack_rise,
  output logic   byte_done
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  phase_e         phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic           done_q;
  logic           last_bit;

  assign phase     = phase_q;
  assign byte_done = done_q;
  assign data_rise = scl_rise && (phase_q == PH_DATA);
  assign ack_rise  = scl_rise && (phase_q == PH_ACK) && !go;
  assign last_bit  = (cnt_q == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= data_rise && last_bit;
      if (go) begin
        phase_q <= PH_DATA;
        cnt_q   <= '0;
      end else if (data_rise) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_bit) phase_q <= PH_ACK;
      end else if (ack_rise) begin
        phase_q <= PH_DONE;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) byte_done |=> !byte_done); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst) (phase_q == PH_DATA && !scl_rise) |=> $stable(cnt_q)); // R4
  AST_DONE_ENTERS_ACK: assert property (@(posedge clk) disable iff (rst) byte_done |-> (phase_q == PH_ACK || phase_q == PH_DATA)); // R5

endmodule

// File: rtl/i2cbs_shift_reg.sv
module i2cbs_shift_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] shreg
);

  logic [DATA_W-1:0] data_q;

  assign shreg = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (load_en) begin
      data_q <= load_data;
    end else if (shift_en) begin
      data_q <= {data_q[DATA_W-2:0], bit_in};
    end
  end

  AST_SHREG_HOLD: assert property (@(posedge clk) disable iff (rst) (!load_en && !shift_en) |=> $stable(data_q)); // R2
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst) (shift_en && !load_en) |=> data_q[0] == $past(bit_in)); // R4

endmodule

// File: rtl/i2cbs_arb_mon.sv
module i2cbs_arb_mon
  import i2cbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [1:0] mode,
  input  logic       data_rise,
  input  logic       ack_rise,
  input  logic       sda_drv,
  input  logic       sda_in,
  input  logic       arb_clr,
  output role_e      role,
  output logic       arb_lost,
  output logic       clk_keep
);

  role_e role_q;
  logic  lost_q;
  logic  keep_q;
  logic  overruled;
  logic  loss_tx;
  logic  loss_rx;

  assign role      = role_q;
  assign arb_lost  = lost_q;
  assign clk_keep  = keep_q;
  assign overruled = sda_drv && !sda_in;
  assign loss_tx   = data_rise && (role_q == ROLE_MTX) && overruled;
  assign loss_rx   = ack_rise && (role_q == ROLE_MRX) && overruled;

  always_ff @(posedge clk) begin
    if (rst) begin
      role_q <= ROLE_SRX;
      lost_q <= 1'b0;
      keep_q <= 1'b1;
    end else begin
      if (go) begin
        role_q <= role_e'(mode);
      end else if (loss_tx || loss_rx) begin
        role_q <= ROLE_SRX;
      end

      if (loss_tx || loss_rx) begin
        lost_q <= 1'b1;
      end else if (arb_clr) begin
        lost_q <= 1'b0;
      end

      if (loss_rx) begin
        keep_q <= 1'b0;
      end else if (arb_clr) begin
        keep_q <= 1'b1;
      end
    end
  end

  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (rst) (lost_q && !arb_clr) |=> lost_q); // R10
  AST_RX_LOSS_HALTS: assert property (@(posedge clk) disable iff (rst) loss_rx |=> (!keep_q && lost_q)); // R8
  AST_TX_LOSS_KEEPS: assert property (@(posedge clk) disable iff (rst) (loss_tx && keep_q) |=> (keep_q && role_q == ROLE_SRX)); // R7
  AST_NO_SLAVE_LOSS: assert property (@(posedge clk) disable iff (rst) (!lost_q && !role_q[1] && !go) |=> !lost_q); // R9

endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter
  import i2cbs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  input  logic [1:0]        mode,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              start,
  input  logic              ack_val,
  input  logic              arb_clr,
  output logic              sda_out,
  output logic [DATA_W-1:0] shreg,
  output logic              byte_done,
  output logic              ack_in,
  output logic              arb_lost,
  output logic              clk_keep,
  output logic [1:0]        role
);

  phase_e            phase;
  role_e             role_q;
  logic [1:0]        role_bits;
  logic              go;
  logic              data_rise;
  logic              ack_rise;
  logic              next_msb;
  logic              sda_q;
  logic              ack_q;
  logic [DATA_W-1:0] shreg_q;

  assign go        = (load || start) && (phase != PH_DATA);
  assign role_bits = role_q;
  assign next_msb  = load ? load_data[DATA_W-1] : shreg_q[DATA_W-1];

  i2cbs_phase_ctrl #(.DATA_W(DATA_W)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .scl_rise  (scl_rise),
    .phase     (phase),
    .data_rise (data_rise),
    .ack_rise  (ack_rise),
    .byte_done (byte_done)
  );

  i2cbs_shift_reg #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load_en   (go && load),
    .load_data (load_data),
    .shift_en  (data_rise),
    .bit_in    (sda_in),
    .shreg     (shreg_q)
  );

  i2cbs_arb_mon u_arb (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .mode      (mode),
    .data_rise (data_rise),
    .ack_rise  (ack_rise),
    .sda_drv   (sda_q),
    .sda_in    (sda_in),
    .arb_clr   (arb_clr),
    .role      (role_q),
    .arb_lost  (arb_lost),
    .clk_keep  (clk_keep)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_q <= 1'b1;
      ack_q <= 1'b1;
    end else begin
      if (go) begin
        sda_q <= mode[0] ? next_msb : 1'b1;
      end else if (scl_fall) begin
        unique case (phase)
          PH_DATA: sda_q <= role_bits[0] ? shreg_q[DATA_W-1] : 1'b1;
          PH_ACK:  sda_q <= role_bits[0] ? 1'b1 : ack_val;
          default: sda_q <= 1'b1;
        endcase
      end
      if (ack_rise) ack_q <= sda_in;
    end
  end

  assign sda_out = sda_q;
  assign ack_in  = ack_q;
  assign shreg   = shreg_q;
  assign role    = role_bits;

  AST_RELEASE_SRX: assert property (@(posedge clk) disable iff (rst) (role_q == ROLE_SRX && phase == PH_DATA && scl_fall && !go) |=> sda_q); // R3
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst) ((phase == PH_IDLE || phase == PH_DONE) && scl_fall && !go) |=> sda_q); // R6
  AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (rst) (phase == PH_DATA && !scl_rise) |=> $stable(shreg_q) && $stable(role_q)); // R2

endmodule

// File: tb/i2c_byte_shifter_tb_top.sv
module i2c_byte_shifter_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic         scl_rise = 0, scl_fall = 0, load = 0, start = 0, ack_val = 1, arb_clr = 0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] load_data = '0;
  logic         other = 1'b1;
  logic         sda_in, sda_out, byte_done, ack_in, arb_lost, clk_keep;
  logic [W-1:0] shreg;
  logic [1:0]   role;

  assign sda_in = sda_out & other;

  i2c_byte_shifter #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
    .mode(mode), .load(load), .load_data(load_data), .start(start), .ack_val(ack_val),
    .arb_clr(arb_clr), .sda_out(sda_out), .shreg(shreg), .byte_done(byte_done),
    .ack_in(ack_in), .arb_lost(arb_lost), .clk_keep(clk_keep), .role(role)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // behavioural reference: position -1 idle, 0..7 data bits, 8 ack bit, 9 after ack
  int m_sh, m_pos, m_role, m_bd, m_arb, m_keep, m_ack, m_sda;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int bus;
    int was_sda;
    bus = m_sda & int'(other);
    was_sda = m_sda;
    m_bd = 0;
    if (rst) begin
      m_sh = 0; m_pos = -1; m_role = 0; m_arb = 0; m_keep = 1; m_ack = 1; m_sda = 1;
      return;
    end
    if (arb_clr) begin
      m_arb = 0; m_keep = 1;
    end
    if ((load || start) && !(m_pos >= 0 && m_pos <= 7)) begin
      m_pos = 0;
      m_role = int'(mode);
      if (load) m_sh = int'(load_data);
      m_sda = (m_role % 2 == 1) ? ((m_sh >> 7) & 1) : 1;
      return;
    end
    if (scl_rise && m_pos >= 0 && m_pos <= 7) begin
      if (m_role == 3 && was_sda == 1 && bus == 0) begin
        m_role = 0; m_arb = 1;
      end
      m_sh = ((m_sh * 2) + bus) % 256;
      if (m_pos == 7) m_bd = 1;
      m_pos++;
    end else if (scl_rise && m_pos == 8) begin
      m_ack = bus;
      if (m_role == 2 && was_sda == 1 && bus == 0) begin
        m_role = 0; m_arb = 1; m_keep = 0;
      end
      m_pos = 9;
    end
    if (scl_fall) begin
      if (m_pos >= 0 && m_pos <= 7) m_sda = (m_role % 2 == 1) ? ((m_sh >> 7) & 1) : 1;
      else if (m_pos == 8) m_sda = (m_role % 2 == 1) ? 1 : int'(ack_val);
      else m_sda = 1;
    end
  endtask

  task automatic compare_all();
    chk("R4", "shreg", 32'(shreg), 32'(m_sh));
    chk("R3", "sda_out", 32'(sda_out), 32'(m_sda));
    chk("R5", "byte_done", 32'(byte_done), 32'(m_bd));
    chk("R6", "ack_in", 32'(ack_in), 32'(m_ack));
    chk("R7", "arb_lost", 32'(arb_lost), 32'(m_arb));
    chk("R8", "clk_keep", 32'(clk_keep), 32'(m_keep));
    chk("R2", "role", 32'(role), 32'(m_role));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    load = 0; start = 0; scl_rise = 0; scl_fall = 0; arb_clr = 0;
  endtask

  task automatic do_bit(input logic peer);
    other = peer;
    scl_fall = 1; cyc();
    cyc();
    scl_rise = 1; cyc();
    cyc();
  endtask

  task automatic xfer(input logic [7:0] peer_byte, input logic peer_ack);
    for (int i = 7; i >= 0; i--) do_bit(peer_byte[i]);
    do_bit(peer_ack);
    other = 1;
    do_bit(1'b1);
  endtask

  task automatic begin_tx(input logic [1:0] md, input logic [7:0] d);
    mode = md; load_data = d; load = 1; cyc();
  endtask

  task automatic begin_rx(input logic [1:0] md, input logic av);
    mode = md; ack_val = av; start = 1; cyc();
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1; cyc(); cyc();
    rst = 0;
    chk("R1", "reset sda_out", 32'(sda_out), 1);
    chk("R1", "reset shreg", 32'(shreg), 0);
    chk("R1", "reset clk_keep", 32'(clk_keep), 1);
    chk("R1", "reset role", 32'(role), 0);
    chk("R1", "reset ack_in", 32'(ack_in), 1);

    // R3 R4: master transmit, peer silent, peer acks
    begin_tx(2'b11, 8'hA5);
    chk("R3", "first bit driven", 32'(sda_out), 1);
    xfer(8'hFF, 1'b0);
    chk("R4", "tx capture", 32'(shreg), 32'hA5);
    chk("R6", "ack seen", 32'(ack_in), 0);
    chk("R9", "no loss", 32'(arb_lost), 0);

    // R7: peer overrules at second bit
    begin_tx(2'b11, 8'hC3);
    xfer(8'h8F, 1'b1);
    chk("R7", "shreg holds bus byte", 32'(shreg), 32'h8F);
    chk("R7", "arb_lost", 32'(arb_lost), 1);
    chk("R7", "role slave rx", 32'(role), 0);
    chk("R7", "clk_keep kept", 32'(clk_keep), 1);

    // R10: sticky until cleared
    repeat (3) cyc();
    chk("R10", "still lost", 32'(arb_lost), 1);
    arb_clr = 1; cyc();
    chk("R10", "cleared", 32'(arb_lost), 0);

    // R2: load mid-byte ignored
    begin_tx(2'b11, 8'h5A);
    for (int i = 7; i >= 4; i--) do_bit(1'b1);
    mode = 2'b10; load_data = 8'h00; load = 1; cyc();
    chk("R2", "role unchanged", 32'(role), 3);
    for (int i = 3; i >= 0; i--) do_bit(1'b1);
    chk("R2", "data intact", 32'(shreg), 32'h5A);
    do_bit(1'b1); do_bit(1'b1);

    // R8: master receive, NACK overruled
    begin_rx(2'b10, 1'b1);
    xfer(8'h3C, 1'b0);
    chk("R8", "rx data", 32'(shreg), 32'h3C);
    chk("R8", "clk_keep dropped", 32'(clk_keep), 0);
    chk("R8", "arb_lost", 32'(arb_lost), 1);
    arb_clr = 1; cyc();
    chk("R10", "clk_keep restored", 32'(clk_keep), 1);

    // R9: NACK released, ACK with peer low, slave transmit overruled
    begin_rx(2'b10, 1'b1);
    xfer(8'h81, 1'b1);
    chk("R9", "nack not lost", 32'(arb_lost), 0);
    begin_rx(2'b10, 1'b0);
    xfer(8'h7E, 1'b0);
    chk("R9", "ack not lost", 32'(arb_lost), 0);
    chk("R9", "keep after ack", 32'(clk_keep), 1);
    begin_tx(2'b01, 8'hFF);
    xfer(8'h00, 1'b0);
    chk("R9", "slave tx no loss", 32'(arb_lost), 0);
    chk("R9", "slave tx role", 32'(role), 1);
    chk("R4", "slave tx capture", 32'(shreg), 0);

    // R6: slave receive returns acknowledge
    begin_rx(2'b00, 1'b0);
    for (int i = 7; i >= 0; i--) do_bit(1'b1);
    other = 1; scl_fall = 1; cyc(); cyc();
    chk("R6", "slave drives ack", 32'(sda_out), 0);
    scl_rise = 1; cyc(); cyc();
    chk("R6", "ack captured", 32'(ack_in), 0);
    do_bit(1'b1);
    chk("R6", "released after byte", 32'(sda_out), 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule